// File: doc/BRIEF.md
# Serial Peripheral Interface Master with Two-Stage Bit-Clock Divider

This block is a synchronous serial port master. A host drives it through a small register interface. It has four word-wide registers: control, prescaler, data and status. Words written to the data register go into an 8-entry transmit queue. The shift engine sends each word most significant bit first on `mosi`. It shifts in exactly one word from `miso` for every word it sends, and places that word in an 8-entry receive queue. Software reads the receive queue through the same data register. Because every sent frame also returns a frame, a send-only transfer still leaves words in the receive queue, and software has to drain them.

The bit clock is the system clock divided by an even prescaler times a second factor of (rate + 1). The idle level of `sck` and the edge on which data is captured are both programmable, so all four SPI modes are available. The frame length can be set from 1 to 16 bits; 8 bits is the usual setting. An internal loopback feeds the outgoing bit stream back into the receiver for self-test. Chip select is not part of the block; a general-purpose output outside it drives the select line.

Register map (2-bit address):
- 0 control: [3:0] frame length minus one, [4] clock idle level (cpol), [5] capture on trailing edge (cpha), [6] loopback, [7] enable, [15:8] rate.
- 1 prescaler: [7:0].
- 2 data: a write pushes to the transmit queue, a read pops from the receive queue.
- 3 status: [0] transmit queue empty, [1] transmit queue full, [2] receive word available, [3] receive queue full, [4] busy, [5] overrun (write 1 to clear).

Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`, and it stays there until the next read.

Top module: `spi_prescaled_master`

## Requirements
- R1: After reset the control register reads 0x0007, the prescaler reads 2, the status reads 0x0001 (only transmit-empty set), and `sck` is low.
- R2: While a frame is shifting, successive `sck` edges are exactly prescaler/2 × (rate + 1) system clock cycles apart. One bit period is therefore prescaler × (rate + 1) cycles.
- R3: A prescaler write stores the written value with bit 0 cleared. A result below 2 is stored as 2, so the register always holds an even value from 2 to 254.
- R4: The control field [3:0] holds the frame length minus one. A frame sends the low N bits of the word, most significant first, using exactly 2N `sck` edges.
- R5: When no frame is shifting, `sck` rests at control bit 4 (cpol). With cpha = 0, the master samples on leading edges and changes `mosi` on trailing edges. With cpha = 1, it changes `mosi` on leading edges (not the first one) and samples on trailing edges.
- R6: Frames start only while the enable bit is 1. Clearing it stops the current frame within two cycles: `sck` returns to the idle level and no receive word is stored.
- R7: Status bit 0 is 1 when the transmit queue is empty. Bit 2 is 1 when the receive queue holds a word. Bit 4 (busy) is 1 while a frame is shifting, or while the port is enabled and the transmit queue is not empty.
- R8: A data write pushes one transmit word. A data read pops one receive word. Reading with the receive queue empty returns 0 and changes nothing.
- R9: Each completed frame stores exactly one receive word. The word holds the N sampled bits in its low bits, with the first sampled bit most significant, and zeros above them.
- R10: With control bit 6 set, the receiver takes the master's own `mosi` stream and ignores `miso`, so each received word equals the sent word's low N bits.
- R11: Each queue holds 8 words. A data write to a full transmit queue is dropped.
- R12: A frame that completes while the receive queue is full is discarded, and the queue contents are kept. Status bit 5 (overrun) is then set, and it stays set until status is written with bit 5 = 1.
- R13: While the enable bit is 1, control writes change only the enable bit and prescaler writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data |
| sck | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench sweeps all four clock modes over several prescaler and rate pairs and over frame lengths of 5, 8 and 16 bits. A slave model captures `mosi` and returns its own words on `miso` while it times every `sck` edge. Swapping the modes separates leading-edge from trailing-edge capture, and the divider pairs separate the prescaler factor from the rate factor. The odd and full-width frame lengths expose masking and bit-count errors that 8-bit frames would hide. Directed sequences then fill both queues past capacity, turn on loopback with a slave that disagrees with the sent data, disable the port in the middle of a frame, and attempt configuration writes while the port is enabled.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_W  = 16;
  localparam int SIZE_W = 4;
  localparam int RATE_W = 8;
  localparam int PS_W   = 8;
  localparam int DIV_W  = 16;

  localparam int ST_TXE = 0;
  localparam int ST_TXF = 1;
  localparam int ST_RXA = 2;
  localparam int ST_RXF = 3;
  localparam int ST_BSY = 4;
  localparam int ST_OVR = 5;
  localparam int ST_W   = 6;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_PRESC = 2'd1,
    A_DATA  = 2'd2,
    A_STAT  = 2'd3
  } addr_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              en;
    logic              loopb;
    logic              cpha;
    logic              cpol;
    logic [SIZE_W-1:0] size_m1;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{rate: '0, en: 1'b0, loopb: 1'b0,
                                 cpha: 1'b0, cpol: 1'b0, size_m1: SIZE_W'(7)};

  // Even value, never below 2
  function automatic logic [PS_W-1:0] fix_prescale(input logic [PS_W-1:0] v);
    logic [PS_W-1:0] e;
    e = {v[PS_W-1:1], 1'b0};
    if (e < PS_W'(2)) e = PS_W'(2);
    return e;
  endfunction

  // System cycles per half bit period
  function automatic logic [DIV_W-1:0] half_len(input logic [PS_W-1:0] ps,
                                                input logic [RATE_W-1:0] rate);
    return DIV_W'(ps >> 1) * (DIV_W'(rate) + DIV_W'(1));
  endfunction

  // Low (m1 + 1) bits set
  function automatic logic [REG_W-1:0] size_mask(input logic [SIZE_W-1:0] m1);
    logic [REG_W:0] t;
    t = (REG_W+1)'(1) << (32'(m1) + 1);
    return REG_W'(t - (REG_W+1)'(1));
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign level   = cnt;
  assign head    = mem[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/spim_rate.sv
module spim_rate #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int W   = REG_W,
  parameter int SW  = SIZE_W,
  localparam int EW = SW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          loopb,
  input  logic [SW-1:0] size_m1,
  input  logic          miso,
  input  logic          tick,
  input  logic          tx_valid,
  input  logic [W-1:0]  tx_word,
  output logic          tx_pop,
  output logic          active,
  output logic          sck,
  output logic          mosi,
  output logic          rx_push,
  output logic [W-1:0]  rx_word,
  output logic          sample_evt,
  output logic          shift_evt
);
  logic [W-1:0]  tx_sh, rx_sh, rx_next;
  logic [EW-1:0] eidx, last_idx;
  logic          step, lead, at_last, rx_in;

  assign last_idx   = {1'b0, size_m1, 1'b1};        // 2N - 1
  assign step       = active && tick;
  assign lead       = ~eidx[0];
  assign at_last    = (eidx == last_idx);
  assign sample_evt = step && (lead ^ cpha);
  assign shift_evt  = step && !(lead ^ cpha) && (eidx != '0) && !at_last;
  assign mosi       = tx_sh[size_m1];
  assign rx_in      = loopb ? mosi : miso;
  assign rx_next    = {rx_sh[W-2:0], rx_in};
  assign rx_push    = step && at_last;
  assign rx_word    = (sample_evt ? rx_next : rx_sh) & size_mask(size_m1);
  assign tx_pop     = en && !active && tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck    <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      eidx   <= '0;
    end else if (!en) begin
      active <= 1'b0;
      sck    <= cpol;
      eidx   <= '0;
    end else if (!active) begin
      sck <= cpol;
      if (tx_valid) begin
        active <= 1'b1;
        tx_sh  <= tx_word;
        rx_sh  <= '0;
        eidx   <= '0;
      end
    end else if (tick) begin
      sck  <= ~sck;
      eidx <= eidx + EW'(1);
      if (sample_evt) rx_sh <= rx_next;
      if (shift_evt)  tx_sh <= tx_sh << 1;
      if (at_last)    active <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_prescaled_master.sv
module spi_prescaled_master
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int LW = ((FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  ctrl_t             ctrl_q, wr_ctrl;
  logic [PS_W-1:0]   presc_q;
  logic              ovr_q;
  logic [REG_W-1:0]  rdata_q, rd_mux;
  logic [DIV_W-1:0]  half;
  logic              tick, active, busy;
  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic              rx_push, rx_pop, rx_empty, rx_full;
  logic [REG_W-1:0]  tx_head, rx_head, rx_word;
  logic [LW-1:0]     tx_level, rx_level;
  logic              sample_evt, shift_evt;
  logic [ST_W-1:0]   status;
  logic              cfg_en, cfg_cpol;
  logic [REG_W-2:0]  cfg_frozen;

  assign wr_ctrl    = ctrl_t'(bus_wdata);
  assign half       = half_len(presc_q, ctrl_q.rate);
  assign tx_push    = bus_wr && (bus_addr == A_DATA);
  assign rx_pop     = bus_rd && (bus_addr == A_DATA);
  assign busy       = active || (ctrl_q.en && !tx_empty);
  assign cfg_en     = ctrl_q.en;
  assign cfg_cpol   = ctrl_q.cpol;
  assign cfg_frozen = {ctrl_q.rate, ctrl_q.loopb, ctrl_q.cpha, ctrl_q.cpol, ctrl_q.size_m1};
  assign bus_rdata  = rdata_q;

  always_comb begin
    status         = '0;
    status[ST_TXE] = tx_empty;
    status[ST_TXF] = tx_full;
    status[ST_RXA] = !rx_empty;
    status[ST_RXF] = rx_full;
    status[ST_BSY] = busy;
    status[ST_OVR] = ovr_q;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  rd_mux = ctrl_q;
      A_PRESC: rd_mux = REG_W'(presc_q);
      A_DATA:  rd_mux = rx_empty ? '0 : rx_head;
      default: rd_mux = REG_W'(status);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      presc_q <= PS_W'(2);
      ovr_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) begin
        if (ctrl_q.en) ctrl_q.en <= wr_ctrl.en;
        else           ctrl_q    <= wr_ctrl;
      end
      if (bus_wr && bus_addr == A_PRESC && !ctrl_q.en)
        presc_q <= fix_prescale(bus_wdata[PS_W-1:0]);
      if (rx_push && rx_full)
        ovr_q <= 1'b1;
      else if (bus_wr && bus_addr == A_STAT && bus_wdata[ST_OVR])
        ovr_q <= 1'b0;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  spim_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
    .head(tx_head), .empty(tx_empty), .full(tx_full), .level(tx_level)
  );

  spim_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word), .pop(rx_pop),
    .head(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level)
  );

  spim_rate #(.DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(active), .half(half), .tick(tick)
  );

  spim_shift #(.W(REG_W), .SW(SIZE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .cpol(ctrl_q.cpol),
    .cpha(ctrl_q.cpha), .loopb(ctrl_q.loopb), .size_m1(ctrl_q.size_m1),
    .miso(miso), .tick(tick), .tx_valid(!tx_empty), .tx_word(tx_head),
    .tx_pop(tx_pop), .active(active), .sck(sck), .mosi(mosi),
    .rx_push(rx_push), .rx_word(rx_word), .sample_evt(sample_evt),
    .shift_evt(shift_evt)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int LW = 4,
  parameter int FW = 15,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_cpol,
  input logic [FW-1:0] cfg_frozen,
  input logic [PW-1:0] presc_q,
  input logic          active,
  input logic          sck,
  input logic          busy,
  input logic          tx_push,
  input logic          tx_pop,
  input logic          tx_full,
  input logic [LW-1:0] tx_level,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_full,
  input logic [LW-1:0] rx_level,
  input logic          ovr_q,
  input logic          sample_evt,
  input logic          shift_evt
);
  // R3: prescaler state always even and at least 2
  p_prescale_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_q[0] == 1'b0) && (presc_q >= PW'(2)));

  // R5: idle clock level follows cpol
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && $stable(cfg_cpol)) |-> (sck == cfg_cpol));

  // R5: sampling and shifting never coincide
  p_edge_roles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_evt && shift_evt));

  // R6: disabled port stops shifting on the next edge
  p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !active);

  // R7: a shifting frame always reports busy
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> busy);

  // R11: push into a full transmit queue is dropped
  p_tx_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && !tx_pop) |=> (tx_level == $past(tx_level)));

  // R12: completion into a full receive queue keeps contents and flags overrun
  p_rx_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_push && !rx_pop) |=> (rx_level == $past(rx_level)) && ovr_q);

  // R13: configuration frozen while enabled
  p_cfg_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_en) |-> ($stable(cfg_frozen) && $stable(presc_q)));
endmodule

bind spi_prescaled_master spim_checker #(
  .LW(LW), .FW(spim_pkg::REG_W - 1), .PW(spim_pkg::PS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
  .cfg_frozen(cfg_frozen), .presc_q(presc_q), .active(active), .sck(sck),
  .busy(busy), .tx_push(tx_push), .tx_pop(tx_pop), .tx_full(tx_full),
  .tx_level(tx_level), .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full),
  .rx_level(rx_level), .ovr_q(ovr_q), .sample_evt(sample_evt),
  .shift_evt(shift_evt)
);

// File: tb/spi_prescaled_master_tb.sv
module spi_prescaled_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        sck, mosi;
  logic        miso = 1'b0;

  int total = 0, bad = 0;
  longint cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_prescaled_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic logic [15:0] mk_ctrl(input int rate, input bit en, input bit lb,
                                          input bit cpha, input bit cpol, input int m1);
    return {8'(rate), en, lb, cpha, cpol, 4'(m1)};
  endfunction

  function automatic logic [15:0] lowmask(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic wait_idle();
    logic [15:0] s;
    do rreg(2'd3, s); while (s[4] || !s[0]);
  endtask

  // slave model
  bit          watch = 0;
  bit          m_cpol, m_cpha;
  int          nb = 8, sbits = 0, exp_half = 1, good_gaps = 0;
  longint      last_cyc = 0;
  logic        prev_sck = 1'b0;
  logic [15:0] sw [16];
  logic [15:0] cap [16];

  always @(negedge clk) begin
    if (watch && sck !== prev_sck) begin
      if (cyc - last_cyc == longint'(exp_half)) good_gaps++;
      last_cyc = cyc;
      if ((sck != m_cpol) ^ m_cpha) begin
        int f, b;
        f = sbits / nb; b = sbits % nb;
        if (f < 16) cap[f][nb-1-b] = mosi;
        sbits++;
        f = sbits / nb; b = sbits % nb;
        if (f < 16) miso = sw[f][nb-1-b];
      end
    end
    prev_sck = sck;
  end

  task automatic run_cfg(input int cfgn, input int mode, input int ps, input int rate,
                         input int m1, input bit lb, input int nfr);
    logic [15:0] txw [16];
    logic [15:0] d, mk;
    m_cpol = mode[1]; m_cpha = mode[0];
    nb = m1 + 1; mk = lowmask(nb);
    exp_half = (ps / 2) * (rate + 1);
    wreg(2'd0, mk_ctrl(rate, 0, lb, mode[0], mode[1], m1));
    wreg(2'd1, 16'(ps));
    for (int i = 0; i < 16; i++) begin
      txw[i] = 16'(cfgn * 40503 + i * 9973 + 16'h5A3C);
      sw[i]  = 16'(cfgn * 7919 + i * 31337) ^ 16'hC3A5;
      cap[i] = '0;
    end
    sbits = 0; good_gaps = 0;
    miso = sw[0][nb-1];
    repeat (2) @(negedge clk);
    watch = 1;
    for (int i = 0; i < nfr; i++) wreg(2'd2, txw[i]);
    wreg(2'd0, mk_ctrl(rate, 1, lb, mode[0], mode[1], m1));
    wait_idle();
    repeat (2) @(negedge clk);
    watch = 0;
    for (int i = 0; i < nfr; i++) begin
      chk($sformatf("R4 R5 mosi frame cfg%0d f%0d", cfgn, i), 32'(cap[i]), 32'(txw[i] & mk));
      rreg(2'd2, d);
      if (lb) chk($sformatf("R10 loopback rx cfg%0d f%0d", cfgn, i), 32'(d), 32'(txw[i] & mk));
      else    chk($sformatf("R9 rx word cfg%0d f%0d", cfgn, i), 32'(d), 32'(sw[i] & mk));
    end
    chk($sformatf("R2 edge spacing cfg%0d", cfgn), 32'(good_gaps), 32'(nfr * (2 * nb - 1)));
    chk($sformatf("R5 idle level cfg%0d", cfgn), 32'(sck), 32'(mode[1]));
    wreg(2'd0, mk_ctrl(rate, 0, lb, mode[0], mode[1], m1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int cfgn;
    int psl [4] = '{2, 4, 6, 2};
    int rtl [4] = '{0, 1, 2, 3};
    int szl [3] = '{7, 4, 15};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 sck at reset", 32'(sck), 32'd0);
    rreg(2'd0, d); chk("R1 control reset", 32'(d), 32'h0007);
    rreg(2'd1, d); chk("R1 prescaler reset", 32'(d), 32'd2);
    rreg(2'd3, d); chk("R1 R7 status reset", 32'(d), 32'h0001);

    // R3 prescaler legalisation
    wreg(2'd1, 16'd5);   rreg(2'd1, d); chk("R3 odd 5", 32'(d), 32'd4);
    wreg(2'd1, 16'd0);   rreg(2'd1, d); chk("R3 zero", 32'(d), 32'd2);
    wreg(2'd1, 16'd1);   rreg(2'd1, d); chk("R3 one", 32'(d), 32'd2);
    wreg(2'd1, 16'd255); rreg(2'd1, d); chk("R3 max", 32'(d), 32'd254);

    // R8 read of empty receive queue
    rreg(2'd2, d); chk("R8 empty read", 32'(d), 32'd0);

    // main sweep: modes x dividers x frame sizes
    cfgn = 0;
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 3; s++) begin
          run_cfg(cfgn, m, psl[k], rtl[k], szl[s], 1'b0, 2);
          cfgn++;
        end
    // R10 loopback in two modes
    run_cfg(cfgn, 1, 4, 0, 7, 1'b1, 3); cfgn++;
    run_cfg(cfgn, 2, 2, 1, 11, 1'b1, 3); cfgn++;

    // R11 / R12 queue limits, loopback, fast clock
    wreg(2'd0, mk_ctrl(0, 0, 1, 0, 0, 7));
    wreg(2'd1, 16'd2);
    for (int i = 0; i < 9; i++) wreg(2'd2, 16'(16'h10 + i));
    rreg(2'd3, d);
    chk("R11 tx full flag", 32'(d[1]), 32'd1);
    chk("R6 R7 disabled with data not busy", 32'(d[4]), 32'd0);
    chk("R7 tx not empty", 32'(d[0]), 32'd0);
    wreg(2'd0, mk_ctrl(0, 1, 1, 0, 0, 7));
    wait_idle();
    rreg(2'd3, d);
    chk("R11 rx full after 8", 32'(d[3]), 32'd1);
    chk("R12 no overrun yet", 32'(d[5]), 32'd0);
    wreg(2'd2, 16'h0099);
    wait_idle();
    rreg(2'd3, d);
    chk("R12 overrun set", 32'(d[5]), 32'd1);
    for (int i = 0; i < 8; i++) begin
      rreg(2'd2, d);
      chk($sformatf("R11 R12 kept word %0d", i), 32'(d), 32'(16'h10 + i));
    end
    rreg(2'd2, d); chk("R8 R11 ninth word dropped", 32'(d), 32'd0);
    rreg(2'd3, d);
    chk("R7 rx empty", 32'(d[2]), 32'd0);
    chk("R12 overrun sticky", 32'(d[5]), 32'd1);
    wreg(2'd3, 16'h0020);
    rreg(2'd3, d); chk("R12 overrun cleared", 32'(d[5]), 32'd0);
    wreg(2'd0, mk_ctrl(0, 0, 0, 0, 0, 7));

    // R6 enable gating and mid-frame stop
    wreg(2'd0, mk_ctrl(9, 0, 0, 0, 1, 7));
    wreg(2'd1, 16'd8);
    wreg(2'd2, 16'h00A5);
    begin
      int moved = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sck !== 1'b1) moved++;
      end
      chk("R6 no shift while disabled", 32'(moved), 32'd0);
    end
    wreg(2'd0, mk_ctrl(9, 1, 0, 0, 1, 7));
    repeat (100) @(negedge clk);
    rreg(2'd3, d); chk("R7 busy mid-frame", 32'(d[4]), 32'd1);
    wreg(2'd0, mk_ctrl(9, 0, 0, 0, 1, 7));
    repeat (2) @(negedge clk);
    chk("R6 sck idle after stop", 32'(sck), 32'd1);
    rreg(2'd3, d);
    chk("R6 not busy after stop", 32'(d[4]), 32'd0);
    chk("R6 no rx word after stop", 32'(d[2]), 32'd0);
    chk("R6 tx drained by stopped frame", 32'(d[0]), 32'd1);

    // R13 configuration frozen while enabled
    wreg(2'd1, 16'd4);
    wreg(2'd0, mk_ctrl(3, 1, 0, 1, 0, 7));
    wreg(2'd0, mk_ctrl(9, 1, 1, 0, 1, 3));
    rreg(2'd0, d); chk("R13 ctrl write ignored", 32'(d), 32'(mk_ctrl(3, 1, 0, 1, 0, 7)));
    wreg(2'd1, 16'd10);
    rreg(2'd1, d); chk("R13 prescaler write ignored", 32'(d), 32'd4);
    wreg(2'd0, 16'h0000);
    rreg(2'd0, d); chk("R13 enable bit still writable", 32'(d), 32'(mk_ctrl(3, 0, 0, 1, 0, 7)));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule